// File: doc/BRIEF.md
# AXI4 Write Burst Store-and-Forward Buffer

This block sits on the write side of an AXI4 link, between an upstream master port and a downstream slave port that share one clock. Write address commands and write data beats go into two separate queues. A queued address command is offered downstream only after every data beat of its burst has been captured, up to and including the beat that carries the last flag. A downstream slave therefore receives each write burst as one unbroken run of beats, however slowly or unevenly the upstream source produced them.

The data queue holds 512 beats and the command queue holds 32 commands. Upstream bursts are limited to 256 beats, so one complete burst always fits in the data store. Write responses are not buffered: the response channel is wired straight through in both directions. Only full AXI4 bursts are in scope. AXI4-Lite traffic, read traffic, clock or width conversion and ID reordering are not handled.

Top module: `wr_pkt_buf`

## Requirements
- R1: After reset both upstream ready outputs are high and both downstream valid outputs (address and data) are low.
- R2: `m_awvalid` is high only while the number of bursts whose last beat has been accepted upstream is greater than the number of address commands already issued downstream. A command whose data has not fully arrived is never offered.
- R3: Address commands leave downstream in the order they were accepted, with ID, address, length, size and burst type unchanged.
- R4: Data beats leave downstream in the order they were accepted, with data, byte strobes and last flag unchanged, and they stay stable while `m_wready` is low.
- R5: A burst's first beat is not offered downstream before its address command has been issued, and after a non-last beat is accepted downstream, `m_wvalid` is high in the very next cycle.
- R6: `s_wready` is low exactly when the data queue holds 512 beats, so no beat is lost.
- R7: `s_awready` is low exactly when the command queue holds 32 commands.
- R8: `s_bid`, `s_bresp`, `s_bvalid` equal `m_bid`, `m_bresp`, `m_bvalid`, and `m_bready` equals `s_bready`, in the same cycle.
- R9: When a burst's data is already complete before its address arrives, and no older command is waiting, `m_awvalid` is high in the cycle right after the address handshake.
- R10: While `m_awvalid` is high and `m_awready` is low, `m_awvalid` stays high and the command fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awid | input | ID_W | Upstream command ID |
| s_awaddr | input | ADDR_W | Upstream command start address |
| s_awlen | input | 8 | Upstream beats minus one (0..255) |
| s_awsize | input | 3 | Upstream beat size code |
| s_awburst | input | 2 | Upstream burst type |
| s_awvalid | input | 1 | Upstream command valid |
| s_awready | output | 1 | Command queue has room |
| s_wdata | input | DATA_W | Upstream beat data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat of burst |
| s_wvalid | input | 1 | Upstream beat valid |
| s_wready | output | 1 | Data queue has room |
| s_bid | output | ID_W | Response ID to upstream |
| s_bresp | output | 2 | Response code to upstream |
| s_bvalid | output | 1 | Response valid to upstream |
| s_bready | input | 1 | Upstream accepts response |
| m_awid | output | ID_W | Downstream command ID |
| m_awaddr | output | ADDR_W | Downstream command address |
| m_awlen | output | 8 | Downstream beats minus one |
| m_awsize | output | 3 | Downstream beat size code |
| m_awburst | output | 2 | Downstream burst type |
| m_awvalid | output | 1 | Downstream command valid |
| m_awready | input | 1 | Downstream accepts command |
| m_wdata | output | DATA_W | Downstream beat data |
| m_wstrb | output | DATA_W/8 | Downstream byte strobes |
| m_wlast | output | 1 | Downstream last beat |
| m_wvalid | output | 1 | Downstream beat valid |
| m_wready | input | 1 | Downstream accepts beat |
| m_bid | input | ID_W | Response ID from downstream |
| m_bresp | input | 2 | Response code from downstream |
| m_bvalid | input | 1 | Response valid from downstream |
| m_bready | output | 1 | Ready passed to downstream |

## Verification
The checks on ordering and on burst completeness assume an upstream that obeys AXI4 rules: valid held with stable payload until ready, exactly `awlen + 1` beats per burst with the last flag on the final one, and bursts no longer than 256 beats. The gap-free property also assumes that each command's data burst eventually reaches the block, because a stored burst is drained only after its own command has been issued. The bench's driver tasks hold each payload until its handshake, build every data burst from the same length value they put on the address channel, and never exceed 256 beats, while downstream ready signals are toggled from a shift-register pattern to exercise back-pressure.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

  localparam int unsigned LEN_W   = 8;
  localparam int unsigned SIZE_W  = 3;
  localparam int unsigned BURST_W = 2;
  localparam int unsigned RESP_W  = 2;

  // Occupancy after one cycle given push and pop events.
  function automatic int unsigned occ_step(int unsigned cur, logic up, logic dn);
    int unsigned nxt;
    nxt = cur;
    if (up && !dn) nxt = cur + 1;
    if (dn && !up) nxt = cur - 1;
    return nxt;
  endfunction

  // Beats in a burst from its length field.
  function automatic int unsigned beats_of(logic [LEN_W-1:0] len);
    return int'(len) + 1;
  endfunction

  // True when a depth is a power of two (pointer wraps naturally).
  function automatic bit is_pow2(int unsigned d);
    return (d != 0) && ((d & (d - 1)) == 0);
  endfunction

endpackage

// File: rtl/wpb_fifo.sv
module wpb_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp, wp_nx, rp_nx;
  logic [CW-1:0]    occ;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  generate
    if (wpb_pkg::is_pow2(DEPTH)) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
    end else begin : g_wrap
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (do_push) wp <= wp_nx;
      if (do_pop)  rp <= rp_nx;
      occ <= CW'(wpb_pkg::occ_step(32'(occ), do_push, do_pop));
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign full  = (occ == CW'(DEPTH));
  assign empty = (occ == '0);

endmodule

// File: rtl/wpb_tally.sv
module wpb_tally #(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= W'(wpb_pkg::occ_step(32'(cnt), inc, dec));
  end

  assign nonzero = (cnt != '0);

endmodule

// File: rtl/wr_pkt_buf.sv
module wr_pkt_buf #(
  parameter int unsigned ID_W       = 4,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DATA_DEPTH = 512,
  parameter int unsigned CMD_DEPTH  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ID_W-1:0]              s_awid,
  input  logic [ADDR_W-1:0]            s_awaddr,
  input  logic [wpb_pkg::LEN_W-1:0]    s_awlen,
  input  logic [wpb_pkg::SIZE_W-1:0]   s_awsize,
  input  logic [wpb_pkg::BURST_W-1:0]  s_awburst,
  input  logic                         s_awvalid,
  output logic                         s_awready,
  input  logic [DATA_W-1:0]            s_wdata,
  input  logic [DATA_W/8-1:0]          s_wstrb,
  input  logic                         s_wlast,
  input  logic                         s_wvalid,
  output logic                         s_wready,
  output logic [ID_W-1:0]              s_bid,
  output logic [wpb_pkg::RESP_W-1:0]   s_bresp,
  output logic                         s_bvalid,
  input  logic                         s_bready,
  output logic [ID_W-1:0]              m_awid,
  output logic [ADDR_W-1:0]            m_awaddr,
  output logic [wpb_pkg::LEN_W-1:0]    m_awlen,
  output logic [wpb_pkg::SIZE_W-1:0]   m_awsize,
  output logic [wpb_pkg::BURST_W-1:0]  m_awburst,
  output logic                         m_awvalid,
  input  logic                         m_awready,
  output logic [DATA_W-1:0]            m_wdata,
  output logic [DATA_W/8-1:0]          m_wstrb,
  output logic                         m_wlast,
  output logic                         m_wvalid,
  input  logic                         m_wready,
  input  logic [ID_W-1:0]              m_bid,
  input  logic [wpb_pkg::RESP_W-1:0]   m_bresp,
  input  logic                         m_bvalid,
  output logic                         m_bready
);
  import wpb_pkg::*;

  localparam int unsigned CMD_W  = ID_W + ADDR_W + LEN_W + SIZE_W + BURST_W;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned BEAT_W = DATA_W + STRB_W + 1;
  localparam int unsigned TALLY_W = $clog2(DATA_DEPTH + 1);

  // Named events, brought out for the checker and waveform reading.
  logic aw_push, aw_pop, w_push, w_pop, burst_done, burst_sent;
  logic cmd_full, cmd_empty, dat_full, dat_empty;
  logic ready_bursts, issued_bursts;
  logic [CMD_W-1:0]  cmd_din, cmd_dout;
  logic [BEAT_W-1:0] beat_din, beat_dout;

  // Upstream acceptance
  assign s_awready  = !cmd_full;
  assign s_wready   = !dat_full;
  assign aw_push    = s_awvalid && s_awready;
  assign w_push     = s_wvalid && s_wready;
  assign burst_done = w_push && s_wlast;

  assign cmd_din  = {s_awid, s_awaddr, s_awlen, s_awsize, s_awburst};
  assign beat_din = {s_wdata, s_wstrb, s_wlast};

  wpb_fifo #(.WIDTH(CMD_W), .DEPTH(CMD_DEPTH)) i_cmd_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (aw_push),
    .din   (cmd_din),
    .pop   (aw_pop),
    .dout  (cmd_dout),
    .full  (cmd_full),
    .empty (cmd_empty)
  );

  wpb_fifo #(.WIDTH(BEAT_W), .DEPTH(DATA_DEPTH)) i_beat_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (w_push),
    .din   (beat_din),
    .pop   (w_pop),
    .dout  (beat_dout),
    .full  (dat_full),
    .empty (dat_empty)
  );

  // Complete bursts stored whose command is not yet issued
  wpb_tally #(.W(TALLY_W)) i_ready_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (burst_done),
    .dec     (aw_pop),
    .nonzero (ready_bursts)
  );

  // Issued commands whose data has not fully left
  wpb_tally #(.W(TALLY_W)) i_issued_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (aw_pop),
    .dec     (burst_sent),
    .nonzero (issued_bursts)
  );

  // Downstream address channel
  assign {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst} = cmd_dout;
  assign m_awvalid = !cmd_empty && ready_bursts;
  assign aw_pop    = m_awvalid && m_awready;

  // Downstream data channel
  assign {m_wdata, m_wstrb, m_wlast} = beat_dout;
  assign m_wvalid   = !dat_empty && issued_bursts;
  assign w_pop      = m_wvalid && m_wready;
  assign burst_sent = w_pop && m_wlast;

  // Response channel straight through
  assign s_bid    = m_bid;
  assign s_bresp  = m_bresp;
  assign s_bvalid = m_bvalid;
  assign m_bready = s_bready;

endmodule

// File: rtl/wpb_checker.sv
module wpb_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned DATA_DEPTH = 512,
  parameter int unsigned CMD_DEPTH  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_wlast,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic [DATA_W-1:0] m_wdata
);
  int unsigned dat_occ, cmd_occ, done_n, issued_n, sent_n;
  logic up_w, up_aw, dn_w, dn_aw;

  assign up_w  = s_wvalid && s_wready;
  assign up_aw = s_awvalid && s_awready;
  assign dn_w  = m_wvalid && m_wready;
  assign dn_aw = m_awvalid && m_awready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dat_occ <= 0; cmd_occ <= 0; done_n <= 0; issued_n <= 0; sent_n <= 0;
    end else begin
      dat_occ <= wpb_pkg::occ_step(dat_occ, up_w, dn_w);
      cmd_occ <= wpb_pkg::occ_step(cmd_occ, up_aw, dn_aw);
      if (up_w && s_wlast) done_n <= done_n + 1;
      if (dn_aw)           issued_n <= issued_n + 1;
      if (dn_w && m_wlast) sent_n <= sent_n + 1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !m_awvalid && !m_wvalid); // R1
  AST_AW_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> done_n > issued_n); // R2
  AST_W_AFTER_AW: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid |-> issued_n > sent_n); // R5
  AST_W_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    dn_w && !m_wlast |=> m_wvalid); // R5
  AST_W_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_wready |-> dat_occ < DATA_DEPTH); // R6
  AST_DATA_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dat_occ == DATA_DEPTH |-> !s_wready); // R6
  AST_CMD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s_awready == (cmd_occ < CMD_DEPTH)); // R7
  AST_B_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid == m_bvalid && m_bready == s_bready); // R8
  AST_AW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr)); // R10

endmodule

bind wr_pkt_buf wpb_checker i_wpb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_awvalid (s_awvalid),
  .s_awready (s_awready),
  .s_wvalid  (s_wvalid),
  .s_wready  (s_wready),
  .s_wlast   (s_wlast),
  .s_bvalid  (s_bvalid),
  .s_bready  (s_bready),
  .m_bvalid  (m_bvalid),
  .m_bready  (m_bready),
  .m_awvalid (m_awvalid),
  .m_awready (m_awready),
  .m_awaddr  (m_awaddr),
  .m_wvalid  (m_wvalid),
  .m_wready  (m_wready),
  .m_wlast   (m_wlast),
  .m_wdata   (m_wdata)
);

// File: tb/test_wr_pkt_buf.sv
module test_wr_pkt_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  s_awid = '0;   logic [31:0] s_awaddr = '0; logic [7:0] s_awlen = '0;
  logic [2:0]  s_awsize = '0; logic [1:0]  s_awburst = '0; logic s_awvalid = 1'b0; logic s_awready;
  logic [31:0] s_wdata = '0;  logic [3:0]  s_wstrb = '0;  logic s_wlast = 1'b0;
  logic s_wvalid = 1'b0; logic s_wready;
  logic [3:0] s_bid; logic [1:0] s_bresp; logic s_bvalid; logic s_bready = 1'b0;
  logic [3:0] m_awid; logic [31:0] m_awaddr; logic [7:0] m_awlen; logic [2:0] m_awsize;
  logic [1:0] m_awburst; logic m_awvalid; logic m_awready = 1'b0;
  logic [31:0] m_wdata; logic [3:0] m_wstrb; logic m_wlast; logic m_wvalid; logic m_wready = 1'b0;
  logic [3:0] m_bid = '0; logic [1:0] m_bresp = '0; logic m_bvalid = 1'b0; logic m_bready;

  wr_pkt_buf i_wr_pkt_buf (.*);

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [48:0] exp_aw[$];
  logic [36:0] exp_w[$];
  int seq = 0, up_done = 0, aw_iss = 0, w_sent = 0;
  bit stall_mode = 0, hold_aw = 0;
  logic [7:0] lf = 8'h5A;

  // Vector: len[15:8] gap[7:4] addr_late[3] stall[2]
  localparam logic [15:0] VEC [7] = '{16'h0000, 16'h0320, 16'h0F04, 16'h0718,
                                      16'hFF04, 16'h1F3C, 16'h0150};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Downstream ready pattern
  initial forever begin
    @(posedge clk); #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    m_wready  = stall_mode ? (lf[0] | lf[1]) : 1'b1;
    m_awready = hold_aw ? 1'b0 : (stall_mode ? lf[2] : 1'b1);
  end

  // Downstream monitor, sampled at the falling edge
  bit prev_mid = 0, w_first = 1;
  always @(negedge clk) if (rst_n) begin
    if (prev_mid) chk(m_wvalid, "R5 no gap", m_wvalid, 1);
    if (m_awvalid && m_awready) begin
      chk(up_done > aw_iss, "R2 data complete", up_done, aw_iss + 1);
      chk(exp_aw.size() > 0 && {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst} == exp_aw[0],
          "R3 command", {m_awid, m_awaddr, m_awlen, m_awsize, m_awburst},
          exp_aw.size() > 0 ? exp_aw[0] : 0);
      if (exp_aw.size() > 0) void'(exp_aw.pop_front());
      aw_iss++;
    end
    prev_mid = 0;
    if (m_wvalid && m_wready) begin
      if (w_first) chk(aw_iss > w_sent, "R5 after command", aw_iss, w_sent + 1);
      chk(exp_w.size() > 0 && {m_wdata, m_wstrb, m_wlast} == exp_w[0], "R4 beat",
          {m_wdata, m_wstrb, m_wlast}, exp_w.size() > 0 ? exp_w[0] : 0);
      if (exp_w.size() > 0) void'(exp_w.pop_front());
      w_first = m_wlast;
      prev_mid = !m_wlast;
      if (m_wlast) w_sent++;
    end
    if (s_wvalid && s_wready && s_wlast) up_done++;
  end

  task automatic send_aw(input int id, input logic [7:0] len, input bit late);
    @(posedge clk); #1;
    s_awid = 4'(id); s_awaddr = 32'h1000 + 32'(id) * 32'h400; s_awlen = len;
    s_awsize = 3'd2; s_awburst = 2'b01; s_awvalid = 1'b1;
    @(negedge clk);
    while (!s_awready) @(negedge clk);
    exp_aw.push_back({s_awid, s_awaddr, s_awlen, s_awsize, s_awburst});
    @(posedge clk); #1;
    s_awvalid = 1'b0;
    if (late) begin
      @(negedge clk);
      chk(m_awvalid, "R9 late address", m_awvalid, 1);
    end
  endtask

  task automatic send_w(input int id, input logic [7:0] len, input int gap);
    for (int b = 0; b <= int'(len); b++) begin
      @(posedge clk); #1;
      s_wdata = {16'(id), 16'(b)}; s_wstrb = 4'(id) ^ 4'(b);
      s_wlast = (b == int'(len)); s_wvalid = 1'b1;
      @(negedge clk);
      while (!s_wready) @(negedge clk);
      exp_w.push_back({s_wdata, s_wstrb, s_wlast});
      @(posedge clk); #1;
      s_wvalid = 1'b0;
      for (int g = 0; g < gap; g++) @(posedge clk);
    end
  endtask

  task automatic drain();
    while (w_sent != seq || aw_iss != seq) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", w_sent, seq);
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_awready && s_wready, "R1 ready after reset", {s_awready, s_wready}, 2'b11);
    chk(!m_awvalid && !m_wvalid, "R1 idle after reset", {m_awvalid, m_wvalid}, 0);
    @(posedge clk); #1; rst_n = 1'b1;

    // Vector table
    for (int v = 0; v < 7; v++) begin
      int id;
      logic [7:0] len;
      int gap;
      id = seq; seq++;
      len = VEC[v][15:8]; gap = int'(VEC[v][7:4]); stall_mode = VEC[v][2];
      if (VEC[v][3]) begin
        send_w(id, len, gap);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!m_awvalid, "R2 no command yet", m_awvalid, 0);
        send_aw(id, len, 1'b1);
      end else begin
        fork
          send_aw(id, len, 1'b0);
          send_w(id, len, gap);
        join
      end
      drain();
    end

    // R7: fill the command queue with no data behind it
    stall_mode = 0; hold_aw = 1;
    for (int k = 0; k < 32; k++) begin send_aw(seq + k, 8'd0, 1'b0); end
    @(negedge clk);
    chk(!s_awready, "R7 command queue full", s_awready, 0);
    chk(!m_awvalid, "R2 commands without data", m_awvalid, 0);
    hold_aw = 0;
    for (int k = 0; k < 32; k++) begin send_w(seq + k, 8'd0, 0); end
    seq += 32;
    drain();

    // R6: fill the data queue with two maximal bursts while commands are held
    hold_aw = 1;
    send_aw(seq, 8'd255, 1'b0);
    send_aw(seq + 1, 8'd255, 1'b0);
    send_w(seq, 8'd255, 0);
    send_w(seq + 1, 8'd255, 0);
    @(negedge clk);
    chk(!s_wready, "R6 data queue full", s_wready, 0);
    chk(!m_wvalid, "R5 data held until command", m_wvalid, 0);
    seq += 2;
    hold_aw = 0;
    drain();
    @(negedge clk);
    chk(s_wready, "R6 room after drain", s_wready, 1);

    // R8: response pass-through
    m_bvalid = 1'b1; m_bid = 4'd5; m_bresp = 2'd2; s_bready = 1'b1;
    #1;
    chk(s_bvalid && s_bid == 4'd5 && s_bresp == 2'd2 && m_bready, "R8 response",
        {s_bvalid, s_bid, s_bresp, m_bready}, {1'b1, 4'd5, 2'd2, 1'b1});
    m_bvalid = 1'b0; m_bid = 4'd9; m_bresp = 2'd1; s_bready = 1'b0;
    #1;
    chk(!s_bvalid && s_bid == 4'd9 && s_bresp == 2'd1 && !m_bready, "R8 response idle",
        {s_bvalid, s_bid, s_bresp, m_bready}, {1'b0, 4'd9, 2'd1, 1'b0});

    // R1: reset again mid-run returns to idle
    @(posedge clk); #1; rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(!m_awvalid && !m_wvalid && s_awready && s_wready, "R1 reset again",
        {m_awvalid, m_wvalid, s_awready, s_wready}, 4'b0011);
    finish_sim();
  end

endmodule